// File: doc/BRIEF.md
# Per-Target Software-Interrupt Acceptance Checker

This block sits beside one target processor and decides whether an incoming software-generated interrupt delivery may mark that interrupt pending. A delivery strobe carries an interrupt number between 0 and 15, the group the sender asked for, and a flag that says whether the sender was non-secure. The block compares the request against two pieces of local state:

- a configured-group table holding one entry per interrupt;
- a 32-bit permission register holding a 2-bit grade per interrupt, which limits what non-secure senders may raise.

A global security-disable input removes the permission gate. An accepted delivery sets the matching bit of a 16-bit pending register. A simple clear port removes pending bits on behalf of acknowledgement or software. The configuration state is loaded through a plain write port.

Each delivery strobe produces a registered verdict one cycle later. Rejected deliveries leave no trace other than that verdict.

Top module: `sgi_accept_top`

## Requirements
- R1: Group codes are 0 = secure group 0, 1 = secure group 1, 2 = non-secure group 1, 3 = reserved. After reset, the pending register and the permission register are zero, every configured group is 0, and no verdict is signalled.
- R2: A request for group 1 (secure group 1) aimed at an interrupt configured as group 0 is handled as a group 0 request.
- R3: After the adjustment in R2, a request whose group differs from the configured group of its interrupt is rejected and leaves the pending register unchanged.
- R4: The permission gate applies only when the sender is non-secure and the security-disable input is low. Secure senders, and all senders while security-disable is high, bypass it.
- R5: The permission grade of interrupt n is bits 2n+1:2n of the permission register.
- R6: Under the gate, a group 0 interrupt needs a grade of at least 1, and a group 1 interrupt needs a grade of at least 2. Otherwise the request is rejected. Group 2 interrupts have no grade requirement.
- R7: An accepted delivery for interrupt n sets pending bit n at the next clock edge. All other bits are unchanged, and a bit that is already set stays set.
- R8: Each set bit of the clear mask clears the matching pending bit at the next edge. When a clear and an accepted set target the same bit in the same cycle, the bit ends up set.
- R9: The verdict valid output is high for exactly the cycle after each strobe, with the accept flag giving the decision. The decision uses the configuration in force before any write made in the same cycle as the strobe.
- R10: A group write stores a 2-bit code into the entry selected by the index. A write of the reserved code 3 is ignored. A permission write replaces the whole 32-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_disable_i | input | 1 | Global security-disable; bypasses the permission gate |
| dlv_valid_i | input | 1 | Delivery strobe |
| dlv_num_i | input | 4 | Interrupt number of the delivery |
| dlv_grp_i | input | 2 | Requested group code |
| dlv_nonsec_i | input | 1 | Sender is non-secure |
| clr_mask_i | input | 16 | Pending bits to clear |
| grp_we_i | input | 1 | Configured-group write enable |
| grp_idx_i | input | 4 | Entry selected by a group write |
| grp_val_i | input | 2 | Group code to store |
| perm_we_i | input | 1 | Permission register write enable |
| perm_data_i | input | 32 | New permission register value |
| pending_o | output | 16 | Pending register |
| verdict_valid_o | output | 1 | A verdict is being reported |
| verdict_accept_o | output | 1 | The reported delivery was accepted |

## Verification
The hardest situations to reach are the ones where several things land on the same edge. In the first, a delivery arrives in the same cycle as a permission write that would change its outcome. In the second, a clear and an accepted set hit the same pending bit. Directed sequences arrange both deliberately: one raises a grade from 0 to 3 in the very cycle a non-secure group 0 delivery arrives, and one clears a bit while re-delivering it. A long pseudo-random phase then mixes deliveries, clears and configuration writes, all compared every cycle against a behavioural model.

// File: rtl/sgi_acc_pkg.sv
// Shared definitions for the software-interrupt acceptance checker.
// Assumes the 2-bit group coding shared with the senders.
package sgi_acc_pkg;
    localparam int GRP_W = 2;

    typedef enum logic [GRP_W-1:0] {
        GRP_SEC0  = 2'd0,
        GRP_SEC1  = 2'd1,
        GRP_NSEC1 = 2'd2,
        GRP_RSVD  = 2'd3
    } grp_e;

    localparam logic [GRP_W-1:0] PERM_MIN_SEC0 = 2'd1;
    localparam logic [GRP_W-1:0] PERM_MIN_SEC1 = 2'd2;
endpackage

// File: rtl/sgi_cfg_store.sv
// Configuration storage: one group code per interrupt plus a packed
// permission register holding PERM_W bits per interrupt.
// Assumes a single write port per table. Writes of the reserved group
// code are discarded.
module sgi_cfg_store
    import sgi_acc_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int PERM_W    = 2,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int PERM_REG_W = NUM_LINES * PERM_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       grp_we,
    input  logic [IDX_W-1:0]           grp_idx,
    input  logic [GRP_W-1:0]           grp_val,
    input  logic                       perm_we,
    input  logic [PERM_REG_W-1:0]      perm_data,
    output logic [NUM_LINES*GRP_W-1:0] grp_tbl,
    output logic [PERM_REG_W-1:0]      perm_reg
);
    // Entries only take the write when the code is not reserved.
    logic grp_write_ok;
    assign grp_write_ok = grp_we && (grp_val != GRP_RSVD);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_entry
        // Holds the configured group of interrupt i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                grp_tbl[i*GRP_W +: GRP_W] <= GRP_SEC0;
            else if (grp_write_ok && (grp_idx == IDX_W'(i)))
                grp_tbl[i*GRP_W +: GRP_W] <= grp_val;
        end

        AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (grp_we && grp_idx == IDX_W'(i) && grp_val == GRP_RSVD)
            |=> $stable(grp_tbl[i*GRP_W +: GRP_W])); // R10
    end

    // Holds the permission grades; a write replaces all of them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perm_reg <= '0;
        else if (perm_we)
            perm_reg <= perm_data;
    end

    AST_PERM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        perm_we |=> (perm_reg == $past(perm_data))); // R10
endmodule

// File: rtl/sgi_accept_logic.sv
// Combinational acceptance decision for one delivery.
// Assumes the configuration inputs reflect the state before any write
// made in this cycle. It folds a secure-group-1 request onto group 0,
// matches the request against the configured group, and grades
// non-secure senders unless security is disabled.
module sgi_accept_logic
    import sgi_acc_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int PERM_W    = 2,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int PERM_REG_W = NUM_LINES * PERM_W
) (
    input  logic                       dlv_valid,
    input  logic [IDX_W-1:0]           dlv_num,
    input  logic [GRP_W-1:0]           dlv_grp,
    input  logic                       dlv_nonsec,
    input  logic                       sec_disable,
    input  logic [NUM_LINES*GRP_W-1:0] grp_tbl,
    input  logic [PERM_REG_W-1:0]      perm_reg,
    output logic                       accept,
    output logic [NUM_LINES-1:0]       set_vec
);
    logic [GRP_W-1:0]  cfg_grp;
    logic [GRP_W-1:0]  eff_grp;
    logic [PERM_W-1:0] grade;
    logic              gate_on;
    logic              grade_ok;

    // Selects the state belonging to the addressed interrupt.
    always_comb begin
        cfg_grp = grp_tbl[dlv_num*GRP_W +: GRP_W];
        grade   = perm_reg[dlv_num*PERM_W +: PERM_W];
    end

    // Folds the request group and applies the graded gate.
    always_comb begin
        eff_grp = dlv_grp;
        if (dlv_grp == GRP_SEC1 && cfg_grp == GRP_SEC0)
            eff_grp = GRP_SEC0;
        gate_on  = dlv_nonsec && !sec_disable;
        grade_ok = 1'b1;
        if (gate_on) begin
            if (cfg_grp == GRP_SEC0 && grade < PERM_W'(PERM_MIN_SEC0))
                grade_ok = 1'b0;
            if (cfg_grp == GRP_SEC1 && grade < PERM_W'(PERM_MIN_SEC1))
                grade_ok = 1'b0;
        end
        accept = dlv_valid && (eff_grp == cfg_grp) && grade_ok;
    end

    // Turns the decision into a one-hot set request.
    always_comb begin
        set_vec = '0;
        if (accept)
            set_vec[dlv_num] = 1'b1;
    end
endmodule

// File: rtl/sgi_pending_reg.sv
// Pending register with per-bit set and clear.
// Assumes the set vector is at most one-hot. A set wins over a clear
// of the same bit.
module sgi_pending_reg #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] set_vec,
    input  logic [NUM_LINES-1:0] clr_mask,
    output logic [NUM_LINES-1:0] pend
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
        // Tracks pending state of interrupt i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (set_vec[i])
                pend[i] <= 1'b1;
            else if (clr_mask[i])
                pend[i] <= 1'b0;
        end

        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(set_vec[i])); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> pend[i]); // R8
        AST_HOLD_UNLESS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr_mask[i]) |=> pend[i]); // R7
    end
endmodule

// File: rtl/sgi_accept_top.sv
// Per-target software-interrupt acceptance checker.
// Assumes at most one delivery per cycle and a synchronous active-low
// reset. Combines the configuration store, the decision logic and the
// pending register, and reports a registered verdict one cycle after
// each delivery strobe.
module sgi_accept_top
    import sgi_acc_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int PERM_W    = 2,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int PERM_REG_W = NUM_LINES * PERM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sec_disable_i,
    input  logic                  dlv_valid_i,
    input  logic [IDX_W-1:0]      dlv_num_i,
    input  logic [1:0]            dlv_grp_i,
    input  logic                  dlv_nonsec_i,
    input  logic [NUM_LINES-1:0]  clr_mask_i,
    input  logic                  grp_we_i,
    input  logic [IDX_W-1:0]      grp_idx_i,
    input  logic [1:0]            grp_val_i,
    input  logic                  perm_we_i,
    input  logic [PERM_REG_W-1:0] perm_data_i,
    output logic [NUM_LINES-1:0]  pending_o,
    output logic                  verdict_valid_o,
    output logic                  verdict_accept_o
);
    logic [NUM_LINES*GRP_W-1:0] grp_tbl;
    logic [PERM_REG_W-1:0]      perm_reg;
    logic                       accept;
    logic [NUM_LINES-1:0]       set_vec;

    sgi_cfg_store #(.NUM_LINES(NUM_LINES), .PERM_W(PERM_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_we    (grp_we_i),
        .grp_idx   (grp_idx_i),
        .grp_val   (grp_val_i),
        .perm_we   (perm_we_i),
        .perm_data (perm_data_i),
        .grp_tbl   (grp_tbl),
        .perm_reg  (perm_reg)
    );

    sgi_accept_logic #(.NUM_LINES(NUM_LINES), .PERM_W(PERM_W)) u_dec (
        .dlv_valid   (dlv_valid_i),
        .dlv_num     (dlv_num_i),
        .dlv_grp     (dlv_grp_i),
        .dlv_nonsec  (dlv_nonsec_i),
        .sec_disable (sec_disable_i),
        .grp_tbl     (grp_tbl),
        .perm_reg    (perm_reg),
        .accept      (accept),
        .set_vec     (set_vec)
    );

    sgi_pending_reg #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_mask (clr_mask_i),
        .pend     (pending_o)
    );

    // Registers the decision for report one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid_o  <= 1'b0;
            verdict_accept_o <= 1'b0;
        end else begin
            verdict_valid_o  <= dlv_valid_i;
            verdict_accept_o <= dlv_valid_i && accept;
        end
    end

    // Values seen by the addressed interrupt, used only by the checks.
    logic [GRP_W-1:0]  cur_cfg_grp;
    logic [PERM_W-1:0] cur_grade;
    assign cur_cfg_grp = grp_tbl[dlv_num_i*GRP_W +: GRP_W];
    assign cur_grade   = perm_reg[dlv_num_i*PERM_W +: PERM_W];

    AST_VERDICT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid_i |=> verdict_valid_o); // R9
    AST_NO_VERDICT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dlv_valid_i |=> !verdict_valid_o); // R9
    AST_GROUP_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid_o && verdict_accept_o) |->
        ($past(dlv_grp_i) == $past(cur_cfg_grp) ||
         ($past(dlv_grp_i) == GRP_SEC1 && $past(cur_cfg_grp) == GRP_SEC0))); // R3
    AST_SEC1_GRADE: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_accept_o && $past(dlv_nonsec_i && !sec_disable_i && cur_cfg_grp == GRP_SEC1))
        |-> ($past(cur_grade) >= PERM_W'(PERM_MIN_SEC1))); // R6
    AST_SEC0_GRADE: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_accept_o && $past(dlv_nonsec_i && !sec_disable_i && cur_cfg_grp == GRP_SEC0))
        |-> ($past(cur_grade) >= PERM_W'(PERM_MIN_SEC0))); // R6
endmodule

// File: tb/sgi_accept_top_tb.sv
// Self-checking bench: a behavioural model is stepped alongside the
// design and every output is compared after every clock edge.
module sgi_accept_top_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sec_disable_i;
    logic        dlv_valid_i;
    logic [3:0]  dlv_num_i;
    logic [1:0]  dlv_grp_i;
    logic        dlv_nonsec_i;
    logic [15:0] clr_mask_i;
    logic        grp_we_i;
    logic [3:0]  grp_idx_i;
    logic [1:0]  grp_val_i;
    logic        perm_we_i;
    logic [31:0] perm_data_i;
    logic [15:0] pending_o;
    logic        verdict_valid_o;
    logic        verdict_accept_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [1:0]  m_grp [16];
    logic [31:0] m_perm;
    logic [15:0] m_pend;

    always #(CLK_P/2) clk = ~clk;

    sgi_accept_top u_dut (
        .clk(clk), .rst_n(rst_n), .sec_disable_i(sec_disable_i),
        .dlv_valid_i(dlv_valid_i), .dlv_num_i(dlv_num_i), .dlv_grp_i(dlv_grp_i),
        .dlv_nonsec_i(dlv_nonsec_i), .clr_mask_i(clr_mask_i),
        .grp_we_i(grp_we_i), .grp_idx_i(grp_idx_i), .grp_val_i(grp_val_i),
        .perm_we_i(perm_we_i), .perm_data_i(perm_data_i),
        .pending_o(pending_o), .verdict_valid_o(verdict_valid_o),
        .verdict_accept_o(verdict_accept_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_accept(logic [3:0] n, logic [1:0] g, bit ns, bit sd);
        logic [1:0] cfg = m_grp[n];
        logic [1:0] req = g;
        int grade = int'((m_perm >> (2 * n)) & 32'h3);
        if (req == 2'd1 && cfg == 2'd0) req = 2'd0;
        if (req != cfg) return 1'b0;
        if (ns && !sd) begin
            if (cfg == 2'd0 && grade < 1) return 1'b0;
            if (cfg == 2'd1 && grade < 2) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic idle();
        sec_disable_i = 0; dlv_valid_i = 0; dlv_num_i = 0; dlv_grp_i = 0;
        dlv_nonsec_i = 0; clr_mask_i = 0; grp_we_i = 0; grp_idx_i = 0;
        grp_val_i = 0; perm_we_i = 0; perm_data_i = 0;
    endtask

    // One clock: predict, advance, compare, update model, return to idle.
    task automatic tick(string tag);
        bit          e_acc;
        logic [15:0] e_pend;
        e_acc  = dlv_valid_i ? m_accept(dlv_num_i, dlv_grp_i, dlv_nonsec_i, sec_disable_i) : 1'b0;
        e_pend = (m_pend & ~clr_mask_i) | (e_acc ? (16'd1 << dlv_num_i) : 16'd0);
        @(posedge clk);
        #(CLK_P/4);
        chk(tag, "verdict_valid", 32'(verdict_valid_o), 32'(dlv_valid_i));
        if (dlv_valid_i) chk(tag, "verdict_accept", 32'(verdict_accept_o), 32'(e_acc));
        chk(tag, "pending", 32'(pending_o), 32'(e_pend));
        m_pend = e_pend;
        if (grp_we_i && grp_val_i != 2'd3) m_grp[grp_idx_i] = grp_val_i;
        if (perm_we_i) m_perm = perm_data_i;
        idle();
    endtask

    task automatic deliver(logic [3:0] n, logic [1:0] g, bit ns, bit sd, string tag);
        dlv_valid_i = 1; dlv_num_i = n; dlv_grp_i = g; dlv_nonsec_i = ns; sec_disable_i = sd;
        tick(tag);
    endtask

    task automatic wr_grp(logic [3:0] n, logic [1:0] g, string tag);
        grp_we_i = 1; grp_idx_i = n; grp_val_i = g;
        tick(tag);
    endtask

    task automatic wr_perm(logic [31:0] v, string tag);
        perm_we_i = 1; perm_data_i = v;
        tick(tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        for (int i = 0; i < 16; i++) m_grp[i] = 2'd0;
        m_perm = 0; m_pend = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst_n = 1;
        chk("R1", "pending after reset", 32'(pending_o), 0);
        chk("R1", "verdict after reset", 32'(verdict_valid_o), 0);

        // R1: groups reset to 0, permission reset to 0
        deliver(4'd5, 2'd0, 0, 0, "R1");
        deliver(4'd6, 2'd0, 1, 0, "R1");
        clr_mask_i = 16'hFFFF; tick("R8");

        // R2: secure group 1 folds onto group 0
        deliver(4'd3, 2'd1, 0, 0, "R2");

        // R3: mismatches
        deliver(4'd4, 2'd2, 0, 0, "R3");
        wr_grp(4'd7, 2'd1, "R10");
        deliver(4'd7, 2'd0, 0, 0, "R3");
        wr_grp(4'd8, 2'd2, "R10");
        deliver(4'd8, 2'd1, 0, 0, "R3");

        // R5 / R6: grades per field
        wr_grp(4'd10, 2'd1, "R10");
        wr_perm((32'd1 << 18) | (32'd2 << 20) | (32'd1 << 14), "R10");
        deliver(4'd9, 2'd0, 1, 0, "R5");
        deliver(4'd7, 2'd1, 1, 0, "R6");
        deliver(4'd10, 2'd1, 1, 0, "R6");
        deliver(4'd8, 2'd2, 1, 0, "R6");
        deliver(4'd4, 2'd0, 1, 0, "R5");

        // R4: bypass by secure sender and by security-disable
        deliver(4'd6, 2'd0, 1, 1, "R4");
        deliver(4'd11, 2'd0, 0, 0, "R4");

        // R7: re-delivery of a set bit
        deliver(4'd9, 2'd0, 1, 0, "R7");

        // R8: clear alone, and clear against set of the same bit
        clr_mask_i = 16'h0020; tick("R8");
        clr_mask_i = 16'h0200; dlv_valid_i = 1; dlv_num_i = 4'd9; dlv_grp_i = 2'd0;
        dlv_nonsec_i = 1; tick("R8");

        // R9: permission write in the same cycle as the delivery
        clr_mask_i = 16'hFFFF; tick("R8");
        perm_we_i = 1; perm_data_i = m_perm | (32'd3 << 22);
        dlv_valid_i = 1; dlv_num_i = 4'd11; dlv_grp_i = 2'd0; dlv_nonsec_i = 1;
        tick("R9");
        deliver(4'd11, 2'd0, 1, 0, "R9");

        // R10: reserved group code is discarded
        wr_grp(4'd12, 2'd3, "R10");
        deliver(4'd12, 2'd0, 0, 0, "R10");
        deliver(4'd12, 2'd3, 0, 0, "R10");

        // Mixed pseudo-random traffic compared each cycle
        for (int c = 0; c < 2000; c++) begin
            logic [31:0] r;
            r = $urandom;
            dlv_valid_i   = r[0] | r[1];
            dlv_num_i     = r[7:4];
            dlv_grp_i     = r[9:8];
            dlv_nonsec_i  = r[10];
            sec_disable_i = (r[13:11] == 3'd0);
            clr_mask_i    = (r[15:14] == 2'd0) ? 16'($urandom) : 16'd0;
            grp_we_i      = (r[18:16] == 3'd0);
            grp_idx_i     = r[23:20];
            grp_val_i     = r[25:24];
            perm_we_i     = (r[29:26] == 4'd0);
            perm_data_i   = $urandom;
            tick("R7");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule